// File: doc/BRIEF.md
# Indexed Block Register Slave for a Clock Generator Control Bus

This block is a two-wire serial slave that holds eight control bytes for a clock generator. A bus master reaches it with an indexed block write or an indexed block read. Both transfers name a starting byte index and carry an explicit byte-count byte. On a read, the slave returns the byte count first and then the register bytes.

SCL and SDA are oversampled from the system clock through two-flop synchronizers. START and STOP are recognised as SDA edges while SCL is high. The slave pulls SDA low through an open-drain enable and never drives it high. The six writable bytes appear as a parallel output bus for the clock generator. Two bytes are read-only: one shows the live state of four status pins, and the other holds a fixed revision and vendor identifier.

Top module: `clkgen_smbus_regfile`

## Requirements
- R1: After reset the writable bytes hold byte1 = 0x7F, byte2 = 0x00, byte3 = 0xFF, byte4 = 0x47, byte5 = 0x9F and byte6 = 0x03. They appear on `ctrl_o` with byte k at bits [8k-1 : 8k-8]. SDA is released.
- R2: A write is START, address 0xD2, index N, count X, then data bytes, and each of these bytes is acknowledged. An acknowledge is SDA held low during the ninth SCL pulse. Data bytes are stored at N, N+1, and so on.
- R3: Only the low three bits of the index are used, and the byte pointer wraps from 7 to 0 on both writes and reads.
- R4: Data bytes aimed at index 0 or 7 are acknowledged, discarded and still advance the pointer.
- R5: Data bytes after the first X of a write are not acknowledged and are not stored.
- R6: A read is START, 0xD2, index N, repeated START, 0xD3. The slave then sends a count byte followed by bytes N, N+1, and so on, MSB first. It keeps sending while the master acknowledges, and it releases SDA after a not-acknowledge.
- R7: The count byte returned on a read is the most recent count written, or 8 if no count has been written since reset.
- R8: Byte 0 reads as {0000, pci_halt_n_i, cpu_halt_n_i, fsel_i[1], fsel_i[0]}, taken when the byte is loaded for sending. Byte 7 reads as {REV_ID, VEND_ID}, which is 0x01 by default.
- R9: An address byte other than 0xD2 or 0xD3 gets no acknowledge. SDA then stays released and the bus is ignored until the next START.
- R10: A START in the middle of a transfer aborts it. The byte in progress is not stored, and address matching starts again.
- R11: The SDA pull-down is switched on only while the synchronized SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Serial clock line from the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| sda_pull_o | output | 1 | Drive SDA low when 1; release when 0 |
| pci_halt_n_i | input | 1 | Status pin shown in byte 0 bit 3 |
| cpu_halt_n_i | input | 1 | Status pin shown in byte 0 bit 2 |
| fsel_i | input | 2 | Frequency-select pins shown in byte 0 bits 1:0 |
| ctrl_o | output | 48 | Writable bytes 1 to 6, byte 1 in the low octet |

## Verification
Each SCL edge reaches the protocol engine three system clocks after it appears at the pad: two synchronizer stages plus one edge register. An acknowledge or a data bit therefore appears on `sda_pull_o` three clocks after the SCL fall that precedes it. A written byte reaches `ctrl_o` two clocks after that, through the registered write strobe and the register itself. The bench model holds every SCL phase for eight clocks. It samples SDA halfway through the SCL-high phase and compares `ctrl_o` only after the STOP, so every result has settled before it is checked. Byte 0 is captured at the acknowledge-clock fall of the previous byte, so the bench changes the status pins only between transfers.

// File: rtl/clkgen_smb_pkg.sv
// Shared constants, the transfer phase type and the power-up values
// of the writable control bytes. Assumes an eight-byte register file.
package clkgen_smb_pkg;

    localparam int REG_COUNT = 8;
    localparam int IDX_W     = $clog2(REG_COUNT);

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ADDR,
        PH_INDEX,
        PH_COUNT,
        PH_WDATA,
        PH_TX
    } phase_t;

    // Power-up value of a writable byte, selected by its index.
    function automatic logic [7:0] rw_default(input int idx);
        case (idx)
            1:       return 8'h7F;
            2:       return 8'h00;
            3:       return 8'hFF;
            4:       return 8'h47;
            5:       return 8'h9F;
            6:       return 8'h03;
            default: return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/smb_line_sync.sv
// Brings SCL and SDA into the system clock domain and derives the
// SCL edges and the START/STOP conditions from them.
// Assumes STAGES >= 2 and lines idle high.
module smb_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_d;
    logic              sda_d;

    // Synchronizer chains, plus one delayed copy for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_d    <= 1'b1;
            sda_d    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
            scl_d    <= scl_pipe[STAGES-1];
            sda_d    <= sda_pipe[STAGES-1];
        end
    end

    assign scl_s     = scl_pipe[STAGES-1];
    assign sda_s     = sda_pipe[STAGES-1];
    assign scl_rise  = scl_s & ~scl_d;
    assign scl_fall  = ~scl_s & scl_d;
    assign start_det = scl_s & scl_d & sda_d & ~sda_s;
    assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/smb_engine.sv
// Bit- and byte-level protocol engine. It matches the address, takes
// the index and the count, issues register writes, and shifts out the
// count and the register bytes on a read. Assumes the inputs come from
// smb_line_sync, so SCL edges are single-cycle pulses.
module smb_engine
    import clkgen_smb_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h69
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_s,
    input  logic             sda_s,
    input  logic             scl_rise,
    input  logic             scl_fall,
    input  logic             start_det,
    input  logic             stop_det,
    output logic             sda_pull_o,
    output logic             wr_en_o,
    output logic [IDX_W-1:0] wr_idx_o,
    output logic [7:0]       wr_data_o,
    output logic [IDX_W-1:0] rd_idx_o,
    input  logic [7:0]       rd_data_i
);

    localparam logic [3:0] BITS_DONE = 4'd8;
    localparam logic [3:0] ACK_DONE  = 4'd9;

    phase_t           phase;
    logic [3:0]       bitcnt;
    logic [7:0]       rx_sh;
    logic [7:0]       tx_sh;
    logic [7:0]       last_cnt;
    logic [7:0]       remaining;
    logic [IDX_W-1:0] ptr;
    logic             tx_first;
    logic             ack_ok;

    // Protocol sequencing: bus conditions, bit shifting and byte decisions.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase      <= PH_IDLE;
            bitcnt     <= '0;
            rx_sh      <= '0;
            tx_sh      <= '0;
            last_cnt   <= 8'(REG_COUNT);
            remaining  <= '0;
            ptr        <= '0;
            tx_first   <= 1'b0;
            ack_ok     <= 1'b0;
            sda_pull_o <= 1'b0;
            wr_en_o    <= 1'b0;
            wr_idx_o   <= '0;
            wr_data_o  <= '0;
        end else begin
            wr_en_o <= 1'b0;
            if (start_det) begin
                phase      <= PH_ADDR;
                bitcnt     <= '0;
                sda_pull_o <= 1'b0;
            end else if (stop_det) begin
                phase      <= PH_IDLE;
                bitcnt     <= '0;
                sda_pull_o <= 1'b0;
            end else if (phase != PH_IDLE) begin
                if (scl_rise) begin
                    if (bitcnt < BITS_DONE) rx_sh <= {rx_sh[6:0], sda_s};
                    if (bitcnt == BITS_DONE) ack_ok <= ~sda_s;
                    bitcnt <= bitcnt + 4'd1;
                end else if (scl_fall) begin
                    if (bitcnt == BITS_DONE) begin
                        case (phase)
                            PH_ADDR: begin
                                if (rx_sh[7:1] == DEV_ADDR) begin
                                    sda_pull_o <= 1'b1;
                                    if (rx_sh[0]) begin
                                        phase    <= PH_TX;
                                        tx_first <= 1'b1;
                                    end else begin
                                        phase <= PH_INDEX;
                                    end
                                end else begin
                                    phase      <= PH_IDLE;
                                    sda_pull_o <= 1'b0;
                                end
                            end
                            PH_INDEX: begin
                                ptr        <= rx_sh[IDX_W-1:0];
                                sda_pull_o <= 1'b1;
                                phase      <= PH_COUNT;
                            end
                            PH_COUNT: begin
                                last_cnt   <= rx_sh;
                                remaining  <= rx_sh;
                                sda_pull_o <= 1'b1;
                                phase      <= PH_WDATA;
                            end
                            PH_WDATA: begin
                                if (remaining != 8'd0) begin
                                    sda_pull_o <= 1'b1;
                                    remaining  <= remaining - 8'd1;
                                    wr_en_o    <= 1'b1;
                                    wr_idx_o   <= ptr;
                                    wr_data_o  <= rx_sh;
                                    ptr        <= ptr + 1'b1;
                                end
                            end
                            PH_TX:   sda_pull_o <= 1'b0;
                            default: sda_pull_o <= 1'b0;
                        endcase
                    end else if (bitcnt == ACK_DONE) begin
                        bitcnt <= '0;
                        if (phase == PH_TX) begin
                            if (ack_ok) begin
                                tx_first <= 1'b0;
                                if (tx_first) begin
                                    tx_sh      <= last_cnt;
                                    sda_pull_o <= ~last_cnt[7];
                                end else begin
                                    tx_sh      <= rd_data_i;
                                    sda_pull_o <= ~rd_data_i[7];
                                    ptr        <= ptr + 1'b1;
                                end
                            end else begin
                                phase      <= PH_IDLE;
                                sda_pull_o <= 1'b0;
                            end
                        end else begin
                            sda_pull_o <= 1'b0;
                        end
                    end else if (phase == PH_TX && bitcnt != 4'd0) begin
                        sda_pull_o <= ~tx_sh[6];
                        tx_sh      <= {tx_sh[6:0], 1'b0};
                    end
                end
            end
        end
    end

    assign rd_idx_o = ptr;

    assert_pull_scl_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pull_o) |-> !scl_s);

    assert_idle_released_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_IDLE) |-> !sda_pull_o);

    assert_start_rearms_R10: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (phase == PH_ADDR && bitcnt == 4'd0 && !wr_en_o));

    assert_bitcnt_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bitcnt <= ACK_DONE);

endmodule

// File: rtl/smb_regfile.sv
// Register file: byte 0 mirrors the status pins, byte 7 is a fixed
// identifier, and the bytes in between are writable with reset defaults.
// Assumes NBYTES >= 3 and a one-cycle write strobe.
module smb_regfile
    import clkgen_smb_pkg::*;
#(
    parameter int         NBYTES  = REG_COUNT,
    parameter logic [3:0] REV_ID  = 4'h0,
    parameter logic [3:0] VEND_ID = 4'h1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [IDX_W-1:0]      wr_idx,
    input  logic [7:0]            wr_data,
    input  logic [IDX_W-1:0]      rd_idx,
    output logic [7:0]            rd_data,
    input  logic [3:0]            stat_i,
    output logic [(NBYTES-2)*8-1:0] ctrl_o
);

    logic [NBYTES*8-1:0] all_bytes;

    for (genvar g = 0; g < NBYTES; g++) begin : g_byte
        if (g == 0) begin : g_status
            assign all_bytes[7:0] = {4'b0000, stat_i};
        end else if (g == NBYTES - 1) begin : g_ident
            assign all_bytes[g*8 +: 8] = {REV_ID, VEND_ID};
        end else begin : g_rw
            logic [7:0] val;
            // Writable byte: load on a matching write strobe.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    val <= rw_default(g);
                end else if (wr_en && wr_idx == IDX_W'(g)) begin
                    val <= wr_data;
                end
            end
            assign all_bytes[g*8 +: 8] = val;

            assert_write_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_en && wr_idx == IDX_W'(g)) |=> (val == $past(wr_data)));
        end
    end

    assign rd_data = all_bytes[rd_idx*8 +: 8];
    assign ctrl_o  = all_bytes[(NBYTES-1)*8-1:8];

    assert_ctrl_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(ctrl_o));

endmodule

// File: rtl/clkgen_smbus_regfile.sv
// Top level: line synchronizer, protocol engine and register file for
// the clock generator's serial control port. SDA is open-drain: the
// pad pulls low while sda_pull_o is 1. Assumes clk is at least about
// 16x faster than SCL.
module clkgen_smbus_regfile
    import clkgen_smb_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h69,
    parameter logic [3:0] REV_ID   = 4'h0,
    parameter logic [3:0] VEND_ID  = 4'h1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        scl_i,
    input  logic        sda_i,
    output logic        sda_pull_o,
    input  logic        pci_halt_n_i,
    input  logic        cpu_halt_n_i,
    input  logic [1:0]  fsel_i,
    output logic [(REG_COUNT-2)*8-1:0] ctrl_o
);

    logic             scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic             wr_en;
    logic [IDX_W-1:0] wr_idx, rd_idx;
    logic [7:0]       wr_data, rd_data;

    smb_line_sync #(.STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    smb_engine #(.DEV_ADDR(DEV_ADDR)) u_engine (
        .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det),
        .sda_pull_o(sda_pull_o), .wr_en_o(wr_en), .wr_idx_o(wr_idx),
        .wr_data_o(wr_data), .rd_idx_o(rd_idx), .rd_data_i(rd_data)
    );

    smb_regfile #(.NBYTES(REG_COUNT), .REV_ID(REV_ID), .VEND_ID(VEND_ID)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(wr_data), .rd_idx(rd_idx), .rd_data(rd_data),
        .stat_i({pci_halt_n_i, cpu_halt_n_i, fsel_i}), .ctrl_o(ctrl_o)
    );

endmodule

// File: tb/tb_clkgen_smbus_regfile.sv
module tb_clkgen_smbus_regfile;

    localparam int Q = 8;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic        rst_n = 1'b0;
    logic        m_scl = 1'b1;
    logic        m_sda = 1'b1;
    logic        pci_n = 1'b1;
    logic        cpu_n = 1'b1;
    logic [1:0]  fsel  = 2'b00;
    wire         sda_pull;
    wire  [47:0] ctrl;
    wire         sda_line = m_sda & ~sda_pull;

    clkgen_smbus_regfile dut (
        .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line),
        .sda_pull_o(sda_pull), .pci_halt_n_i(pci_n), .cpu_halt_n_i(cpu_n),
        .fsel_i(fsel), .ctrl_o(ctrl)
    );

    int         n_checks = 0;
    int         n_fail   = 0;
    int         viol     = 0;
    bit         done     = 1'b0;
    logic       prev_pull = 1'b0;
    logic [7:0] exp_b [1:6];
    logic [7:0] rbuf  [0:15];
    logic [7:0] rcnt;
    logic       ackv;

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [47:0] exp_ctrl();
        return {exp_b[6], exp_b[5], exp_b[4], exp_b[3], exp_b[2], exp_b[1]};
    endfunction

    task automatic qw();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; m_scl = 1'b1; qw();
        m_sda = 1'b0; qw();
        m_scl = 1'b0; qw();
    endtask

    task automatic bus_rstart();
        m_sda = 1'b1; qw();
        m_scl = 1'b1; qw();
        m_sda = 1'b0; qw();
        m_scl = 1'b0; qw();
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; qw();
        m_scl = 1'b1; qw();
        m_sda = 1'b1; qw();
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            m_sda = b[i]; qw();
            m_scl = 1'b1; qw(); qw();
            m_scl = 1'b0; qw();
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        send_bits(b, 8);
        m_sda = 1'b1; qw();
        m_scl = 1'b1; qw();
        ack = ~sda_line; qw();
        m_scl = 1'b0; qw();
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] b);
        m_sda = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            qw();
            m_scl = 1'b1; qw();
            b[i] = sda_line; qw();
            m_scl = 1'b0; qw();
        end
        m_sda = ~give_ack; qw();
        m_scl = 1'b1; qw(); qw();
        m_scl = 1'b0; qw();
        m_sda = 1'b1;
    endtask

    task automatic wbyte(input logic [7:0] b, input string tag);
        logic a;
        send_byte(b, a);
        check(tag, a, 1'b1);
    endtask

    task automatic do_read(input logic [7:0] idx, input int n);
        bus_start();
        wbyte(8'hD2, "R6 write-address ack");
        wbyte(idx, "R6 index ack");
        bus_rstart();
        wbyte(8'hD3, "R6 read-address ack");
        recv_byte(1'b1, rcnt);
        for (int i = 0; i < n; i++) recv_byte(i != n - 1, rbuf[i]);
        check("R6 SDA released after not-acknowledge", sda_pull, 1'b0);
        bus_stop();
    endtask

    // R11 monitor: the pull-down must never switch on while SCL is high.
    always @(negedge clk) begin
        if (sda_pull && !prev_pull && m_scl) viol++;
        prev_pull = sda_pull;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        exp_b[1] = 8'h7F; exp_b[2] = 8'h00; exp_b[3] = 8'hFF;
        exp_b[4] = 8'h47; exp_b[5] = 8'h9F; exp_b[6] = 8'h03;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R1 reset state
        check("R1 reset ctrl_o", ctrl, exp_ctrl());
        check("R1 reset SDA released", sda_pull, 1'b0);

        // R7 count is 8 before any write; R6 read bytes 2..3
        do_read(8'h02, 2);
        check("R7 default count", rcnt, 8'd8);
        check("R6 read byte2", rbuf[0], 8'h00);
        check("R6 read byte3", rbuf[1], 8'hFF);

        // R2 block write of three bytes from index 1
        bus_start();
        wbyte(8'hD2, "R2 address ack"); wbyte(8'h01, "R2 index ack");
        wbyte(8'h03, "R2 count ack");
        wbyte(8'hA1, "R2 data ack"); wbyte(8'hB2, "R2 data ack"); wbyte(8'hC3, "R2 data ack");
        bus_stop();
        exp_b[1] = 8'hA1; exp_b[2] = 8'hB2; exp_b[3] = 8'hC3;
        check("R2 ctrl after write", ctrl, exp_ctrl());

        do_read(8'h01, 3);
        check("R7 count follows last write", rcnt, 8'd3);
        check("R6 read byte1", rbuf[0], 8'hA1);
        check("R6 read byte2", rbuf[1], 8'hB2);
        check("R6 read byte3", rbuf[2], 8'hC3);

        // R3 index 14 wraps to 6; R4 bytes 7 and 0 acknowledged but discarded
        bus_start();
        wbyte(8'hD2, "R3 address ack"); wbyte(8'h0E, "R3 index ack");
        wbyte(8'h04, "R3 count ack");
        wbyte(8'h55, "R3 data ack"); wbyte(8'h66, "R4 read-only ack");
        wbyte(8'h77, "R4 read-only ack"); wbyte(8'h88, "R3 wrapped data ack");
        bus_stop();
        exp_b[6] = 8'h55; exp_b[1] = 8'h88;
        check("R3 R4 ctrl after wrapped write", ctrl, exp_ctrl());

        // R8 sweep of all sixteen status pin patterns through byte 0
        for (int s = 0; s < 16; s++) begin
            pci_n = s[3]; cpu_n = s[2]; fsel = s[1:0];
            repeat (4) @(negedge clk);
            do_read(8'h00, 1);
            check("R8 status byte0", rbuf[0], {4'b0000, 4'(s)});
            check("R7 count after wrapped write", rcnt, 8'd4);
        end

        // R8 identifier and R3 read wrap 7 -> 0 -> 1
        do_read(8'h07, 3);
        check("R8 identifier byte7", rbuf[0], 8'h01);
        check("R3 wrapped read byte0", rbuf[1], 8'h0F);
        check("R3 wrapped read byte1", rbuf[2], 8'h88);

        // R5 byte beyond count is not acknowledged and not stored
        bus_start();
        wbyte(8'hD2, "R5 address ack"); wbyte(8'h04, "R5 index ack");
        wbyte(8'h01, "R5 count ack"); wbyte(8'h12, "R5 data within count ack");
        send_byte(8'h34, ackv);
        check("R5 extra byte not acknowledged", ackv, 1'b0);
        bus_stop();
        exp_b[4] = 8'h12;
        check("R5 ctrl after over-long write", ctrl, exp_ctrl());

        // R9 unmatched address
        bus_start();
        send_byte(8'hA0, ackv);
        check("R9 foreign address not acknowledged", ackv, 1'b0);
        send_byte(8'h04, ackv);
        check("R9 following byte ignored", ackv, 1'b0);
        send_byte(8'hEE, ackv);
        check("R9 SDA stays released", ackv, 1'b0);
        bus_stop();
        check("R9 ctrl unchanged", ctrl, exp_ctrl());

        // R10 START mid-byte aborts; then a fresh write proceeds
        bus_start();
        wbyte(8'hD2, "R10 address ack"); wbyte(8'h03, "R10 index ack");
        wbyte(8'h02, "R10 count ack");
        send_bits(8'hF0, 4);
        bus_rstart();
        check("R10 aborted byte not stored", ctrl, exp_ctrl());
        wbyte(8'hD2, "R10 re-match address ack"); wbyte(8'h03, "R10 index ack");
        wbyte(8'h01, "R10 count ack"); wbyte(8'h5A, "R10 data ack");
        bus_stop();
        exp_b[3] = 8'h5A;
        check("R10 ctrl after restarted write", ctrl, exp_ctrl());

        // R11 pull-down never switched on while SCL high
        check("R11 pull-down rises with SCL high", viol, 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule